// File: doc/BRIEF.md
# LCD line and frame timing divider

This block turns a free-running oscillator clock into the two timing references an LCD scan engine needs: a line-rate enable and a frame polarity signal. A prescaler divides the oscillator by one of sixteen ratios between 1 and 8.5 in steps of one half. The ratio is picked by a 3-bit coarse value and a half-step flag. Half-integer ratios are built by alternating short and long periods, so the average rate is exact.

A second stage counts the line-rate pulses. It wraps after the programmed panel line count plus one. On each wrap it inverts the frame signal and raises a one-cycle frame tick. New ratio and line-count settings are only taken when the matching counter wraps, so a period or frame that is already running is never cut short or stretched. Everything runs in the oscillator domain. All outputs come straight from registers.

Top module: `lcd_frame_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `line_en`, `frame_out` and `frame_tick` are all 0 after that edge.
- R2: With `half_step` = 0 and coarse value c (0..7) on `coarse_sel`, `line_en` is high in exactly one cycle out of every c+1 cycles.
- R3: With `half_step` = 1 and coarse value c, the gaps between consecutive `line_en` pulses alternate between c+1 and c+2 cycles. Any two neighbouring gaps differ and sum to 2c+3.
- R4: With `coarse_sel` = 0 and `half_step` = 0, `line_en` is high in every cycle (divide by exactly 1).
- R5: With line count L on `line_count`, `frame_out` inverts once after every L+1 `line_en` pulses. It never changes in a cycle that does not follow a `line_en` pulse.
- R6: `frame_tick` is high for one cycle exactly in those cycles where `frame_out` has just changed.
- R7: The time between frame inversions is (c+1)·(L+1) oscillator cycles when `half_step` = 0. It is (2c+3)·(L+1)/2 cycles when `half_step` = 1 and L+1 is even.
- R8: A new `coarse_sel`/`half_step` value applied in the middle of a prescaler period leaves that period's length unchanged. It takes effect from the next period.
- R9: A new `line_count` applied in the middle of a frame leaves that frame's length unchanged. It takes effect from the next frame.
- R10: With `line_count` = 0, `frame_out` inverts on every `line_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_sel | input | 3 | Coarse prescale value c; the ratio is c+1 |
| half_step | input | 1 | Adds one half to the prescale ratio |
| line_count | input | 8 | Panel line count L; a frame is L+1 line pulses |
| line_en | output | 1 | Single-cycle line-rate enable |
| frame_out | output | 1 | Frame polarity, inverted at every frame wrap |
| frame_tick | output | 1 | One-cycle pulse in the cycle `frame_out` changes |

## Verification
A `line_en` pulse appears one cycle after the prescaler counter reaches its last state. The frame inversion and tick appear one cycle after the `line_en` pulse that wraps the line counter. The bench therefore measures gaps between pulses and edges, never absolute times. It samples on the falling edge and counts a line pulse seen in the same sample as a frame edge toward the new frame. After any settings change, the bench throws away one full prescaler period or frame before it measures, because the new value only loads at the next wrap. Only the R8 and R9 directed cases time the period or frame that is in progress when the change is made.

// File: rtl/lcdft_pkg.sv
package lcdft_pkg;

  // Default field widths shared by the divider stages.
  localparam int COARSE_W_DEF = 3;
  localparam int LINE_W_DEF   = 8;

  // Which of the two integer periods the prescaler is producing when a
  // half-step ratio is active.
  typedef enum logic {
    PH_SHORT = 1'b0,
    PH_LONG  = 1'b1
  } half_phase_e;

  // Longest prescaler period in oscillator cycles for a given coarse width.
  function automatic int max_period(input int coarse_w);
    return (1 << coarse_w) + 1;
  endfunction

endpackage

// File: rtl/lcdft_prescaler.sv
module lcdft_prescaler
  import lcdft_pkg::*;
#(
  parameter int COARSE_W = COARSE_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COARSE_W-1:0] coarse_sel,
  input  logic                half_step,
  output logic                line_en
);

  localparam int MAX_LEN = max_period(COARSE_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [COARSE_W-1:0] coarse_q;
  logic                half_q;
  half_phase_e         phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    last_idx;
  logic                wrap;
  logic                extra;

  // Period length is coarse+1, plus one more cycle on the long half-step phase.
  always_comb begin
    extra    = half_q && (phase_q == PH_LONG);
    last_idx = CNT_W'(coarse_q) + CNT_W'(extra);
    wrap     = (cnt_q == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      coarse_q <= '0;
      half_q   <= 1'b0;
      phase_q  <= PH_SHORT;
      line_en  <= 1'b0;
    end else begin
      line_en <= wrap;
      if (wrap) begin
        cnt_q    <= '0;
        coarse_q <= coarse_sel;
        half_q   <= half_step;
        if (half_step && phase_q == PH_SHORT) phase_q <= PH_LONG;
        else                                  phase_q <= PH_SHORT;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // The counter never passes the last index of the running period (R2).
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx);

  // Held settings only move on a wrap (R8).
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(coarse_q) && $stable(half_q)));

  // Without the half step the long phase is never used (R3).
  p_phase_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !half_q |-> (phase_q == PH_SHORT));

  // Reset silences the line enable (R1).
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !line_en);

endmodule

// File: rtl/lcdft_line_div.sv
module lcdft_line_div
  import lcdft_pkg::*;
#(
  parameter int LINE_W = LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_en,
  input  logic [LINE_W-1:0] line_count,
  output logic              frame_out,
  output logic              frame_tick
);

  logic [LINE_W-1:0] lcnt_q;
  logic [LINE_W-1:0] lc_q;
  logic              wrap;

  assign wrap = line_en && (lcnt_q == lc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt_q     <= '0;
      lc_q       <= '0;
      frame_out  <= 1'b0;
      frame_tick <= 1'b0;
    end else begin
      frame_tick <= wrap;
      if (wrap) begin
        lcnt_q    <= '0;
        lc_q      <= line_count;
        frame_out <= ~frame_out;
      end else if (line_en) begin
        lcnt_q <= lcnt_q + 1'b1;
      end
    end
  end

  // Line counter stays inside the held frame length (R5).
  p_lcnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    lcnt_q <= lc_q);

  // Frame level only moves after a line pulse (R5).
  p_frame_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !line_en |=> $stable(frame_out));

  // Tick marks a fresh frame edge (R6).
  p_tick_edge_r6: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> (frame_out != $past(frame_out)));

  // Held line count only reloads at a frame wrap (R9).
  p_lc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(lc_q));

  // Reset clears frame outputs (R1).
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!frame_out && !frame_tick));

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcdft_pkg::*;
#(
  parameter int COARSE_W = COARSE_W_DEF,
  parameter int LINE_W   = LINE_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COARSE_W-1:0] coarse_sel,
  input  logic                half_step,
  input  logic [LINE_W-1:0]   line_count,
  output logic                line_en,
  output logic                frame_out,
  output logic                frame_tick
);

  logic line_pulse;

  lcdft_prescaler #(
    .COARSE_W (COARSE_W)
  ) u_prescaler (
    .clk        (clk),
    .rst        (rst),
    .coarse_sel (coarse_sel),
    .half_step  (half_step),
    .line_en    (line_pulse)
  );

  lcdft_line_div #(
    .LINE_W (LINE_W)
  ) u_line_div (
    .clk        (clk),
    .rst        (rst),
    .line_en    (line_pulse),
    .line_count (line_count),
    .frame_out  (frame_out),
    .frame_tick (frame_tick)
  );

  assign line_en = line_pulse;

  // A tick can only follow a line pulse (R6).
  p_tick_after_line_r6: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> $past(line_pulse));

endmodule

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] coarse_sel = '0;
  logic       half_step = 1'b0;
  logic [7:0] line_count = '0;
  logic       line_en, frame_out, frame_tick;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  lcd_frame_timer u_lcd_frame_timer (
    .clk        (clk),
    .rst        (rst),
    .coarse_sel (coarse_sel),
    .half_step  (half_step),
    .line_count (line_count),
    .line_en    (line_en),
    .frame_out  (frame_out),
    .frame_tick (frame_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_cycles(input int c, input bit h, input int l);
    if (h) return ((2 * c + 3) * (l + 1)) / 2;
    return (c + 1) * (l + 1);
  endfunction

  // Gap in samples until the next line pulse.
  task automatic next_line(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!line_en && gap < 5000);
  endtask

  // Samples until frame_out changes; also checks the tick along the way.
  task automatic wait_change(output int cyc, output int lines, output int tick_err);
    bit prev;
    bit ch;
    prev = frame_out;
    cyc = 0; lines = 0; tick_err = 0;
    do begin
      @(negedge clk);
      cyc++;
      ch = (frame_out != prev);
      if (frame_tick != ch) tick_err++;
      prev = frame_out;
      if (!ch) lines += int'(line_en);
    end while (!ch && cyc < 40000);
  endtask

  // Measures one complete frame span, discarding the one in progress.
  task automatic frame_span(output int cyc, output int lines, output int tick_err);
    int c0, l0, t0, first;
    wait_change(c0, l0, t0);
    first = int'(line_en);
    wait_change(cyc, lines, tick_err);
    lines += first;
    tick_err += t0;
  endtask

  task automatic set_cfg(input int c, input bit h, input int l);
    @(negedge clk);
    coarse_sel = 3'(c);
    half_step  = h;
    line_count = 8'(l);
  endtask

  task automatic test_prescale(input int c, input bit h);
    int g1, g2, g3, g4, d;
    set_cfg(c, h, 0);
    next_line(d); next_line(d);
    next_line(g1); next_line(g2); next_line(g3); next_line(g4);
    if (!h) begin
      chk(g1 == c + 1, "R2", g1, c + 1);
      chk(g2 == c + 1 && g3 == c + 1 && g4 == c + 1, "R2", g4, c + 1);
    end else begin
      chk(g1 + g2 == 2 * c + 3, "R3", g1 + g2, 2 * c + 3);
      chk(g2 != g3 && (g3 == c + 1 || g3 == c + 2), "R3", g3, c + 1);
      chk(g3 + g4 == 2 * c + 3, "R3", g3 + g4, 2 * c + 3);
    end
  endtask

  task automatic test_frame(input int c, input bit h, input int l);
    int cyc, lines, te, d;
    set_cfg(c, h, l);
    next_line(d); next_line(d);
    frame_span(cyc, lines, te);
    frame_span(cyc, lines, te);
    chk(lines == l + 1, (l == 0) ? "R10" : "R5", lines, l + 1);
    chk(te == 0, "R6", te, 0);
    if (!h || ((l + 1) % 2 == 0))
      chk(cyc == frame_cycles(c, h, l), "R7", cyc, frame_cycles(c, h, l));
  endtask

  initial begin
    int g, cyc, lines, te, ones;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(line_en == 0 && frame_out == 0 && frame_tick == 0, "R1",
        {line_en, frame_out, frame_tick}, 0);
    @(negedge clk); rst = 1'b0;

    // R4: divide by one keeps line_en high
    set_cfg(0, 0, 0);
    repeat (2) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ones += int'(line_en);
    end
    chk(ones == 12, "R4", ones, 12);

    // R2 / R3 across all coarse values
    for (int c = 0; c < 8; c++) test_prescale(c, 0);
    for (int c = 0; c < 8; c++) test_prescale(c, 1);

    // R8: change mid-period keeps the running period
    set_cfg(7, 0, 0);
    next_line(g); next_line(g); next_line(g);
    @(negedge clk); @(negedge clk);
    coarse_sel = 3'd0;
    next_line(g);
    chk(g + 2 == 8, "R8", g + 2, 8);
    next_line(g);
    chk(g == 1, "R8", g, 1);

    // R10 / R5 / R6 / R7 directed
    test_frame(0, 0, 0);
    test_frame(2, 0, 3);
    test_frame(4, 1, 5);
    test_frame(0, 0, 255);

    // R9: line count change mid-frame keeps the running frame
    set_cfg(0, 0, 3);
    frame_span(cyc, lines, te);
    wait_change(cyc, lines, te);
    @(negedge clk);
    line_count = 8'd0;
    wait_change(cyc, lines, te);
    chk(cyc + 1 == 4, "R9", cyc + 1, 4);
    wait_change(cyc, lines, te);
    chk(cyc == 1, "R9", cyc, 1);

    // Random mix
    for (int k = 0; k < 10; k++) begin
      int c, l;
      bit h;
      c = int'($urandom_range(0, 7));
      h = 1'($urandom_range(0, 1));
      l = int'($urandom_range(0, 31));
      test_frame(c, h, l);
    end

    // R1: reset in the middle of operation
    set_cfg(3, 1, 2);
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(line_en == 0 && frame_out == 0 && frame_tick == 0, "R1",
        {line_en, frame_out, frame_tick}, 0);
    rst = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule